// File: doc/BRIEF.md
# Decode-Stage Stall Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It finds the operand dependencies that the forwarding network cannot cover in time, and it stops the front of the pipeline while the producing instruction moves forward. Each cycle it receives three descriptions. The first is the instruction waiting in the fetch/decode register: its two source register numbers and whether it is a compare-in-decode branch. The second is the instruction in the execute stage: whether it is a load, whether it writes a register, and its destination. The third is the instruction in the memory stage: whether it is a load, and its destination.

When a hazard is found, the controller holds the program counter and the fetch/decode register, so the same instruction is decoded again and its successor is fetched again. In the same cycle it requests a bubble, which zeroes the control fields that enter the execute stage. Most hazards need one stall cycle. A branch that compares the result of the load directly in front of it needs more. A small synchronous counter covers the remaining cycles of that stall without looking at the inputs.

Top module: `hz_stall_ctrl`

## Requirements
- R1: When the execute-stage instruction is a load (`ex_mem_read`=1) and its non-zero destination equals `dec_rs` or `dec_rt`, all three stall outputs are 1 in that same cycle. This applies whether or not the decode instruction is a branch.
- R2: `pc_hold`, `fd_hold` and `ex_bubble` carry the same value in every cycle.
- R3: A branch (`dec_is_branch`=1) stalls for exactly one cycle when the execute-stage instruction writes a register without being a load and its non-zero destination matches `dec_rs` or `dec_rt`.
- R4: A branch stalls for exactly one cycle when the memory-stage instruction is a load (`mem_mem_read`=1) and its non-zero destination matches `dec_rs` or `dec_rt`.
- R5: A branch whose source matches the non-zero destination of an execute-stage load stalls in that cycle and in the following LB_STALL-1 cycles (two cycles in total by default). The extra cycles happen whatever the inputs are during them.
- R6: A destination register number of 0 never causes a stall.
- R7: No stall in these cases: a non-branch behind an execute-stage non-load writer; a non-branch behind a memory-stage load; a branch behind a memory-stage non-load; a producer whose destination matches neither source; an execute-stage instruction that neither loads nor writes.
- R8: A synchronous active-high `rst` clears the stall counter. A two-cycle branch stall that is detected in a reset cycle gets no extra cycle. With quiet inputs after reset, all outputs are 0.
- R9: A dependent-load branch pattern seen during an extra stall cycle does not lengthen the stall. The stall ends after LB_STALL cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_rs | input | REG_W | First source register of the decode instruction |
| dec_rt | input | REG_W | Second source register of the decode instruction |
| dec_is_branch | input | 1 | Decode instruction is a branch resolved in decode |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_W | Execute-stage destination register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | REG_W | Memory-stage destination register |
| pc_hold | output | 1 | Keep the program counter unchanged |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged |
| ex_bubble | output | 1 | Zero the control fields entering execute |

## Verification
Directed sequences present each producer kind (execute load, execute ALU writer, memory load, memory ALU writer) to branch and non-branch consumers. This separates the case that stalls from the three near cases that must not, and it tells a match on Rs apart from a match on Rt. Register 0 is placed in every producer slot to show that the zero guard applies per stage. The two-cycle branch-after-load is followed by quiet inputs, by a repeat of the same pattern, and by a reset, which checks that the counter runs by itself, is not reloaded and is cleared. Random descriptors drawn from a four-register pool then produce frequent chance matches against a cycle-accurate bench model.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_LOAD_USE,
        CAUSE_BR_ALU,
        CAUSE_BR_LOAD_FAR,
        CAUSE_BR_LOAD_NEAR
    } cause_e;

    localparam int unsigned PROD_KINDS = 3; // ex load, ex alu writer, mem load
    localparam int unsigned PK_EX_LOAD = 0;
    localparam int unsigned PK_EX_ALU  = 1;
    localparam int unsigned PK_MEM_LD  = 2;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int unsigned REG_W = 5
) (
    input  logic             prod_en,
    input  logic [REG_W-1:0] prod_dst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    output logic             hit
);
    logic dst_live;
    logic any_eq;

    always_comb begin
        dst_live = (prod_dst != '0);
        any_eq   = (prod_dst == src_a) || (prod_dst == src_b);
        hit      = prod_en && dst_live && any_eq;
    end
endmodule

// File: rtl/hz_classify.sv
module hz_classify
    import hz_pkg::*;
(
    input  logic                  is_branch,
    input  logic [PROD_KINDS-1:0] hits,
    output cause_e                cause
);
    always_comb begin
        cause = CAUSE_NONE;
        if (is_branch && hits[PK_EX_LOAD]) begin
            cause = CAUSE_BR_LOAD_NEAR;
        end else if (hits[PK_EX_LOAD]) begin
            cause = CAUSE_LOAD_USE;
        end else if (is_branch && hits[PK_EX_ALU]) begin
            cause = CAUSE_BR_ALU;
        end else if (is_branch && hits[PK_MEM_LD]) begin
            cause = CAUSE_BR_LOAD_FAR;
        end
    end
endmodule

// File: rtl/hz_seq.sv
module hz_seq
    import hz_pkg::*;
#(
    parameter int unsigned LB_STALL = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  cause_e cause,
    output logic   stall,
    output logic   forced
);
    localparam int unsigned CNT_W = $clog2(LB_STALL + 1);
    localparam logic [CNT_W-1:0] EXTRA = CNT_W'(LB_STALL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        forced = (st_q.cnt != '0);
        stall  = 1'b0;
        if (forced) begin
            stall      = 1'b1;
            st_d.cnt   = st_q.cnt - 1'b1;
        end else if (cause == CAUSE_BR_LOAD_NEAR) begin
            stall      = 1'b1;
            st_d.cnt   = EXTRA;
        end else begin
            stall      = (cause != CAUSE_NONE);
        end
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned REG_W    = 5,
    parameter int unsigned LB_STALL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0] dec_rt,
    input  logic             dec_is_branch,
    input  logic             ex_mem_read,
    input  logic             ex_reg_write,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             mem_mem_read,
    input  logic [REG_W-1:0] mem_dst,
    output logic             pc_hold,
    output logic             fd_hold,
    output logic             ex_bubble
);
    logic [PROD_KINDS-1:0]            prod_en;
    logic [PROD_KINDS-1:0][REG_W-1:0] prod_dst;
    logic [PROD_KINDS-1:0]            hits;
    cause_e                           cause;
    logic                             stall;
    logic                             forced;

    always_comb begin
        prod_en[PK_EX_LOAD]  = ex_mem_read;
        prod_dst[PK_EX_LOAD] = ex_dst;
        prod_en[PK_EX_ALU]   = ex_reg_write && !ex_mem_read;
        prod_dst[PK_EX_ALU]  = ex_dst;
        prod_en[PK_MEM_LD]   = mem_mem_read;
        prod_dst[PK_MEM_LD]  = mem_dst;
    end

    for (genvar k = 0; k < PROD_KINDS; k++) begin : g_match
        hz_src_match #(.REG_W(REG_W)) u_match (
            .prod_en  (prod_en[k]),
            .prod_dst (prod_dst[k]),
            .src_a    (dec_rs),
            .src_b    (dec_rt),
            .hit      (hits[k])
        );
    end

    hz_classify u_cls (
        .is_branch (dec_is_branch),
        .hits      (hits),
        .cause     (cause)
    );

    hz_seq #(.LB_STALL(LB_STALL)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .cause  (cause),
        .stall  (stall),
        .forced (forced)
    );

    always_comb begin
        pc_hold   = stall;
        fd_hold   = stall;
        ex_bubble = stall;
    end
endmodule

// File: rtl/hz_stall_checker.sv
module hz_stall_checker #(
    parameter int unsigned REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] dec_rs,
    input logic [REG_W-1:0] dec_rt,
    input logic             dec_is_branch,
    input logic             ex_mem_read,
    input logic             ex_reg_write,
    input logic [REG_W-1:0] ex_dst,
    input logic             mem_mem_read,
    input logic [REG_W-1:0] mem_dst,
    input logic             pc_hold,
    input logic             fd_hold,
    input logic             ex_bubble,
    input logic             forced
);
    logic ex_src_eq, mem_src_eq;
    assign ex_src_eq  = (ex_dst != '0) && ((ex_dst == dec_rs) || (ex_dst == dec_rt));
    assign mem_src_eq = (mem_dst != '0) && ((mem_dst == dec_rs) || (mem_dst == dec_rt));

    a_r2_holds_agree: assert property (@(posedge clk) disable iff (rst)
        (pc_hold == fd_hold) && (fd_hold == ex_bubble));

    a_r1_load_use: assert property (@(posedge clk) disable iff (rst)
        (ex_mem_read && ex_src_eq) |-> (ex_bubble && pc_hold));

    a_r3_branch_alu: assert property (@(posedge clk) disable iff (rst)
        (dec_is_branch && ex_reg_write && !ex_mem_read && ex_src_eq) |-> fd_hold);

    a_r4_branch_far_load: assert property (@(posedge clk) disable iff (rst)
        (dec_is_branch && mem_mem_read && mem_src_eq) |-> ex_bubble);

    a_r5_second_cycle: assert property (@(posedge clk) disable iff (rst)
        (!forced && dec_is_branch && ex_mem_read && ex_src_eq) |=> (pc_hold && forced));

    a_r6_zero_dst: assert property (@(posedge clk) disable iff (rst)
        (!forced && ex_dst == '0 && mem_dst == '0) |-> !ex_bubble);
endmodule

bind hz_stall_ctrl hz_stall_checker #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dec_rs        (dec_rs),
    .dec_rt        (dec_rt),
    .dec_is_branch (dec_is_branch),
    .ex_mem_read   (ex_mem_read),
    .ex_reg_write  (ex_reg_write),
    .ex_dst        (ex_dst),
    .mem_mem_read  (mem_mem_read),
    .mem_dst       (mem_dst),
    .pc_hold       (pc_hold),
    .fd_hold       (fd_hold),
    .ex_bubble     (ex_bubble),
    .forced        (forced)
);

// File: tb/sim_hz_stall_ctrl.sv
module sim_hz_stall_ctrl;
    localparam int unsigned RW = 5;
    localparam int unsigned LB = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [RW-1:0] dec_rs, dec_rt, ex_dst, mem_dst;
    logic          dec_is_branch, ex_mem_read, ex_reg_write, mem_mem_read;
    logic          pc_hold, fd_hold, ex_bubble;

    int checks = 0;
    int errors = 0;
    int mcnt   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    hz_stall_ctrl #(.REG_W(RW), .LB_STALL(LB)) u0 (
        .clk(clk), .rst(rst),
        .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_is_branch(dec_is_branch),
        .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write), .ex_dst(ex_dst),
        .mem_mem_read(mem_mem_read), .mem_dst(mem_dst),
        .pc_hold(pc_hold), .fd_hold(fd_hold), .ex_bubble(ex_bubble)
    );

    function automatic bit dep(bit en, logic [RW-1:0] d, logic [RW-1:0] a, logic [RW-1:0] b);
        return en && (d != 0) && ((d == a) || (d == b));
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one cycle at the falling edge, check before the rising edge, advance model.
    task automatic step(string tag, bit r, bit br, int rs, int rt,
                        bit exm, bit exw, int exd, bit mm, int md);
        bit exp_stall;
        int nxt;
        rst = r; dec_is_branch = br; dec_rs = RW'(rs); dec_rt = RW'(rt);
        ex_mem_read = exm; ex_reg_write = exw; ex_dst = RW'(exd);
        mem_mem_read = mm; mem_dst = RW'(md);
        #2;
        if (mcnt != 0) begin
            exp_stall = 1'b1; nxt = mcnt - 1;
        end else if (br && dep(exm, RW'(exd), RW'(rs), RW'(rt))) begin
            exp_stall = 1'b1; nxt = LB - 1;
        end else begin
            exp_stall = dep(exm, RW'(exd), RW'(rs), RW'(rt))
                     || (br && dep(exw && !exm, RW'(exd), RW'(rs), RW'(rt)))
                     || (br && dep(mm, RW'(md), RW'(rs), RW'(rt)));
            nxt = 0;
        end
        if (r) nxt = 0;
        checks++;
        if (pc_hold !== exp_stall || fd_hold !== exp_stall || ex_bubble !== exp_stall) begin
            errors++;
            $display("FAIL %s: pc/fd/bub=%b%b%b expected %b%b%b",
                     tag, pc_hold, fd_hold, ex_bubble, exp_stall, exp_stall, exp_stall);
        end
        @(posedge clk);
        mcnt = nxt;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; dec_is_branch = 0; dec_rs = 0; dec_rt = 0;
        ex_mem_read = 0; ex_reg_write = 0; ex_dst = 0; mem_mem_read = 0; mem_dst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mcnt = 0;
        // R8: reset state and quiet inputs
        step("R8 reset", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R8 quiet", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: load-use on Rs and Rt
        step("R1 rs", 0, 0, 3, 4, 1, 1, 3, 0, 0);
        step("R1 rt", 0, 0, 3, 4, 1, 1, 4, 0, 0);
        step("R2 after", 0, 0, 3, 4, 0, 0, 0, 0, 0);
        // R6: zero destinations
        step("R6 ex load", 0, 0, 0, 4, 1, 1, 0, 0, 0);
        step("R6 ex alu br", 0, 1, 0, 0, 0, 1, 0, 0, 0);
        step("R6 mem load br", 0, 1, 0, 2, 0, 0, 0, 1, 0);
        // R3: branch behind ALU writer, one cycle
        step("R3 stall", 0, 1, 5, 6, 0, 1, 6, 0, 0);
        step("R3 release", 0, 1, 5, 6, 0, 0, 0, 0, 0);
        // R7: near misses
        step("R7 nonbr alu", 0, 0, 5, 6, 0, 1, 5, 0, 0);
        step("R7 nonbr memld", 0, 0, 5, 6, 0, 0, 0, 1, 6);
        step("R7 br mem alu", 0, 1, 5, 6, 0, 0, 0, 0, 5);
        step("R7 mismatch", 0, 1, 5, 6, 1, 1, 7, 1, 8);
        step("R7 no write", 0, 1, 5, 6, 0, 0, 5, 0, 0);
        // R4: branch behind far load
        step("R4 stall", 0, 1, 9, 2, 0, 0, 0, 1, 2);
        step("R4 release", 0, 1, 9, 2, 0, 0, 0, 0, 0);
        // R5: branch behind near load, extra cycle with quiet inputs
        step("R5 first", 0, 1, 7, 1, 1, 1, 7, 0, 0);
        step("R5 second", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R5 release", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9: repeat pattern during extra cycle does not extend
        step("R9 first", 0, 1, 7, 1, 1, 1, 1, 0, 0);
        step("R9 second", 0, 1, 7, 1, 1, 1, 1, 0, 0);
        step("R9 release", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: reset cancels the extra cycle
        step("R8 near in rst", 1, 1, 7, 1, 1, 1, 7, 0, 0);
        step("R8 no extra", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: random descriptor mix, small register pool
        for (int i = 0; i < 600; i++) begin
            step("R2 random", ($urandom % 50) == 0, $urandom % 2,
                 $urandom % 4, $urandom % 4, ($urandom % 3) == 0, $urandom % 2,
                 $urandom % 4, ($urandom % 3) == 0, $urandom % 4);
        end
        finish_run();
    end
endmodule